// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key FIFO

The block walks a key matrix of up to eight scan rows by eight return columns, one row at a time. Each row is held for a fixed number of clock cycles. In the last cycle of that dwell the block samples the return lines for the active row. A key that reads closed on two visits in a row is accepted. The block then builds an eight-bit code from the control and shift inputs, the row and the column, and pushes that code into an eight-entry queue.

A CPU uses a small synchronous register port with two read targets and one write target.
- A command write selects the scan style, the key policy and the matrix size, or clears the queue.
- A data read pops the oldest code.
- A status read returns the fill level and an overrun flag.

The interrupt request stays high while the queue holds at least one code.

The scan style is selectable:
- **Decoded:** the block drives one active-low line per row.
- **Encoded:** the block drives a binary row number for an external decoder.

The key policy is also selectable:
- **Two-key lockout:** only one held key is admitted at a time.
- **N-key rollover:** every debounced closure is admitted on its own.

Top module: `keymatrix_scanner`

## Requirements
- R1: During and right after reset, the queue is empty, `irq` is low, the status reads 0x00, and `scan_o` is 0xFE (decoded scan, row 0). The reset configuration is decoded scan, two-key lockout and an 8x8 matrix.
- R2: In decoded mode, exactly one line of `scan_o` is low: line i when row i is active. The active row stays for DWELL_CYC cycles and then moves to the next row, wrapping after the last enabled row.
- R3: In encoded mode, `scan_o[2:0]` carries the active row number and all higher lines are 0. The row sequence and dwell are the same as in decoded mode.
- R4: Command opcode 001 sets the number of enabled rows minus one from data bits [2:0]. Opcode 010 does the same for columns. A value of 0 is raised to 1, so the smallest matrix is 2x2. Rows beyond the limit are never scanned, and columns beyond the limit are treated as open.
- R5: A key is accepted only when it reads closed on two consecutive visits to its row. A closure seen on a single visit produces nothing. A held key produces one code. The same key can produce a new code only after one visit reads it open, followed again by two closed visits.
- R6: Each queued code is {control, shift, row[2:0], column[2:0]} from bit 7 down to bit 0. The control and shift levels are the ones present when the key is accepted.
- R7: Command opcode 000 with data bit 1 = 0 selects two-key lockout. A debounced key is refused while any other accepted key is still held, and it is admitted at a later visit once the held key has been seen released.
- R8: Opcode 000 with data bit 1 = 1 selects N-key rollover, where each debounced key is admitted whatever else is held. Data bit 0 of the same opcode selects encoded (1) or decoded (0) scan. At most one key is admitted per row visit, taking the lowest column first.
- R9: The queue holds up to eight codes and returns them in acceptance order. A data read (`rd_en`=1, `rd_sel`=0) presents the oldest code on `rd_data` and removes it at that clock edge.
- R10: An accepted key that arrives when eight codes are waiting is dropped, and status bit 6 (overrun) is set. The flag stays set through later reads.
- R11: Command opcode 110 empties the queue and clears overrun. Opcodes 011, 100, 101 and 111 change nothing.
- R12: A status read (`rd_sel`=1) returns the fill count in bits [3:0] and overrun in bit 6, with all other bits 0. `irq` is high exactly when the count is non-zero. A data read of an empty queue returns 0x00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_o | output | ROWS | Row drive: one-cold lines (decoded) or row number (encoded) |
| ret_n | input | COLS | Return lines, low when the key at the active row is closed |
| shift_i | input | 1 | Shift level stored with each accepted key |
| ctrl_i | input | 1 | Control level stored with each accepted key |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte, opcode in bits [7:5] |
| rd_en | input | 1 | Read strobe; pops the queue when `rd_sel` is 0 |
| rd_sel | input | 1 | Read target: 0 = key code, 1 = status |
| rd_data | output | 8 | Read data, valid in the same cycle as the select |
| irq | output | 1 | High while the queue is not empty |

## Verification
The checker assumes a clean matrix:
- `ret_n` reflects only the row on `scan_o`.
- The shift and control levels do not change while a key is being accepted.
- No pop arrives in the same cycle as a push into a full queue.

The bench's matrix model derives the active row from `scan_o` in either scan style and drives the return lines from a table of held keys. Every key is held or released for whole multiples of the scan period, and shift and control are set before a press and kept until after the release. Reads are issued only after all keys are released, so no read meets a push.

// File: rtl/kms_pkg.sv
package kms_pkg;

    // Command opcodes carried in bits [7:5] of a command byte
    typedef enum logic [2:0] {
        OP_MODE  = 3'b000,
        OP_ROWS  = 3'b001,
        OP_COLS  = 3'b010,
        OP_CLEAR = 3'b110
    } kms_op_e;

    // One queued key code, control in the top bit
    typedef struct packed {
        logic       ctrl;
        logic       shift;
        logic [2:0] row;
        logic [2:0] col;
    } kms_entry_t;

    // Live configuration set by commands
    typedef struct packed {
        logic       enc_scan;
        logic       nkro;
        logic [2:0] row_last;
        logic [2:0] col_last;
    } kms_cfg_t;

endpackage

// File: rtl/kms_cmd.sv
// kms_cmd: decodes command bytes into the scan configuration and a one-cycle
// clear strobe. Assumes ROWS and COLS lie between 2 and 8. Opcodes outside the
// decoded set are ignored.
module kms_cmd
    import kms_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output kms_cfg_t   cfg,
    output logic       clear_o
);
    localparam logic [2:0] ROW_TOP = 3'(ROWS - 1);
    localparam logic [2:0] COL_TOP = 3'(COLS - 1);

    kms_op_e op;
    assign op = kms_op_e'(wr_data[7:5]);

    // Keep a size field between one (a 2-line matrix) and the built size
    function automatic logic [2:0] fit_last(input logic [2:0] v, input logic [2:0] top);
        if (v == 3'd0) return 3'd1;
        if (v > top)   return top;
        return v;
    endfunction

    // Configuration register update on command writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{enc_scan: 1'b0, nkro: 1'b0, row_last: ROW_TOP, col_last: COL_TOP};
        end else if (wr_en) begin
            case (op)
                OP_MODE: begin
                    cfg.enc_scan <= wr_data[0];
                    cfg.nkro     <= wr_data[1];
                end
                OP_ROWS: cfg.row_last <= fit_last(wr_data[2:0], ROW_TOP);
                OP_COLS: cfg.col_last <= fit_last(wr_data[2:0], COL_TOP);
                default: ;
            endcase
        end
    end

    // Clear strobe for the queue
    assign clear_o = wr_en && (op == OP_CLEAR);

endmodule

// File: rtl/kms_scan_timer.sv
// kms_scan_timer: holds each row for DWELL_CYC cycles, raises tick in the last
// cycle of the dwell, and drives the row lines decoded (one-cold) or encoded
// (binary). Assumes DWELL_CYC >= 2 and row_last < ROWS.
module kms_scan_timer #(
    parameter int ROWS      = 8,
    parameter int DWELL_CYC = 4,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int CNT_W    = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_scan,
    input  logic [ROW_W-1:0] row_last,
    output logic [ROWS-1:0]  scan_o,
    output logic [ROW_W-1:0] row,
    output logic             tick
);
    logic [CNT_W-1:0] dwell_cnt;

    assign tick = (dwell_cnt == CNT_W'(DWELL_CYC - 1));

    // Dwell counter within one row
    always_ff @(posedge clk) begin
        if (!rst_n) dwell_cnt <= '0;
        else        dwell_cnt <= tick ? '0 : dwell_cnt + 1'b1;
    end

    // Active row, wrapping after the last enabled row
    always_ff @(posedge clk) begin
        if (!rst_n)    row <= '0;
        else if (tick) row <= (row >= row_last) ? '0 : row + 1'b1;
    end

    // Line drive: bits below ROW_W can carry the binary row number
    for (genvar i = 0; i < ROWS; i++) begin : g_line
        if (i < ROW_W) begin : g_code
            assign scan_o[i] = enc_scan ? row[i] : (row != ROW_W'(i));
        end else begin : g_plain
            assign scan_o[i] = enc_scan ? 1'b0 : (row != ROW_W'(i));
        end
    end

endmodule

// File: rtl/kms_debounce.sv
// kms_debounce: keeps a last-sample bit and an accepted bit per key. On each row
// sample it admits at most one key (the lowest column) that read closed on this
// and the previous visit and is not yet accepted. In lockout mode it refuses
// while any accepted key is held. Assumes ROWS and COLS at most 8.
module kms_debounce
    import kms_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int KEYS  = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [ROW_W-1:0] row,
    input  logic [COLS-1:0]  ret_n,
    input  logic [COL_W-1:0] col_last,
    input  logic             nkro,
    input  logic             shift_i,
    input  logic             ctrl_i,
    output logic             push,
    output kms_entry_t       entry
);
    logic [KEYS-1:0]  prev_q, down_q, prev_d, down_d;
    logic [COLS-1:0]  closed, cand;
    logic [COL_W-1:0] pick_col;
    logic             have_pick;
    int               base;

    // Closed keys in the active row and their admission candidates
    always_comb begin
        base = int'(row) * COLS;
        for (int c = 0; c < COLS; c++) begin
            closed[c] = !ret_n[c] && (COL_W'(c) <= col_last);
            cand[c]   = closed[c] && prev_q[base + c] && !down_q[base + c];
        end
    end

    // Lowest-column candidate wins this visit
    always_comb begin
        have_pick = 1'b0;
        pick_col  = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (cand[c]) begin
                have_pick = 1'b1;
                pick_col  = COL_W'(c);
            end
        end
    end

    assign push = sample && have_pick && (nkro || (down_q == '0));

    // Code formed from the live modifier levels and the key position
    always_comb begin
        entry.ctrl  = ctrl_i;
        entry.shift = shift_i;
        entry.row   = 3'(row);
        entry.col   = 3'(pick_col);
    end

    // Next key state for the sampled row
    always_comb begin
        prev_d = prev_q;
        down_d = down_q;
        if (sample) begin
            for (int c = 0; c < COLS; c++) begin
                prev_d[base + c] = closed[c];
                down_d[base + c] = closed[c] &&
                                   (down_q[base + c] || (push && (pick_col == COL_W'(c))));
            end
        end
    end

    // Key state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            down_q <= '0;
        end else begin
            prev_q <= prev_d;
            down_q <= down_d;
        end
    end

endmodule

// File: rtl/kms_fifo.sv
// kms_fifo: circular queue of key codes. A push into a full queue is dropped and
// sets overrun. Clear wins over push and pop in the same cycle. Head reads zero
// when empty. Assumes DEPTH >= 2.
module kms_fifo #(
    parameter int DEPTH  = 8,
    parameter int W      = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop_req,
    input  logic             clear,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             overrun,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full && !clear;
    assign pop_ok  = pop_req && (count != '0) && !clear;

    // Pointer advance with wrap at DEPTH
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers, fill count and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok)      wr_ptr  <= step(wr_ptr);
            if (pop_ok)       rd_ptr  <= step(rd_ptr);
            if (push && full) overrun <= 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign head = (count != '0) ? mem[rd_ptr] : '0;

endmodule

// File: rtl/keymatrix_scanner.sv
// keymatrix_scanner: top level. Ties the command decoder, the row timer, the
// per-key debounce and the code queue to a synchronous register port. Assumes
// the matrix drives ret_n low only for closed keys in the row shown on scan_o.
module keymatrix_scanner
    import kms_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int DWELL_CYC = 4,
    parameter int DEPTH     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [ROWS-1:0] scan_o,
    input  logic [COLS-1:0] ret_n,
    input  logic            shift_i,
    input  logic            ctrl_i,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            rd_en,
    input  logic            rd_sel,
    output logic [7:0]      rd_data,
    output logic            irq
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam int CNT_W = $clog2(DEPTH + 1);

    kms_cfg_t         cfg;
    kms_entry_t       entry;
    logic             clear, tick, push, pop_req, overrun, full;
    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] count;
    logic [7:0]       head, status;

    kms_cmd #(.ROWS(ROWS), .COLS(COLS)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .clear_o (clear)
    );

    kms_scan_timer #(.ROWS(ROWS), .DWELL_CYC(DWELL_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enc_scan (cfg.enc_scan),
        .row_last (cfg.row_last[ROW_W-1:0]),
        .scan_o   (scan_o),
        .row      (row),
        .tick     (tick)
    );

    kms_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (tick),
        .row      (row),
        .ret_n    (ret_n),
        .col_last (cfg.col_last[COL_W-1:0]),
        .nkro     (cfg.nkro),
        .shift_i  (shift_i),
        .ctrl_i   (ctrl_i),
        .push     (push),
        .entry    (entry)
    );

    kms_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (entry),
        .pop_req   (pop_req),
        .clear     (clear),
        .head      (head),
        .count     (count),
        .overrun   (overrun),
        .full      (full)
    );

    assign pop_req = rd_en && !rd_sel;
    assign irq     = (count != '0);

    // Status byte: overrun in bit 6, fill count in the low bits
    always_comb begin
        status              = '0;
        status[6]           = overrun;
        status[CNT_W-1:0]   = count;
    end

    assign rd_data = rd_sel ? status : head;

endmodule

// File: rtl/keymatrix_scanner_chk.sv
// keymatrix_scanner_chk: temporal checks on the scanner, attached by bind.
module keymatrix_scanner_chk #(
    parameter int ROWS  = 8,
    parameter int DEPTH = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enc,
    input logic [ROWS-1:0]  scan_o,
    input logic [ROW_W-1:0] row,
    input logic             tick,
    input logic             push,
    input logic             full,
    input logic             clear,
    input logic             pop_req,
    input logic [CNT_W-1:0] count,
    input logic             overrun
);
    // R2
    one_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc |-> ($countones(~scan_o) == 1));

    // R3
    encoded_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc |-> ((scan_o >> ROW_W) == '0));

    // R2
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(row));

    // R5
    push_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tick);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clear) |=> overrun);

    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !overrun));

    // R9
    pop_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && count != '0 && !push && !clear) |=> (count == CNT_W'($past(count) - 1'b1)));

endmodule

bind keymatrix_scanner keymatrix_scanner_chk #(.ROWS(ROWS), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enc     (cfg.enc_scan),
    .scan_o  (scan_o),
    .row     (row),
    .tick    (tick),
    .push    (push),
    .full    (full),
    .clear   (clear),
    .pop_req (pop_req),
    .count   (count),
    .overrun (overrun)
);

// File: tb/keymatrix_scanner_bench.sv
module keymatrix_scanner_bench;
    localparam int SCAN = 32;   // 8 rows x 4 cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  scan_o, ret_n, rd_data;
    logic [7:0]  wr_data = 8'h00;
    logic        shift_i = 1'b0, ctrl_i = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic        irq;
    logic [63:0] pressed = '0;
    int          cur_row;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    keymatrix_scanner u_keymatrix_scanner (
        .clk(clk), .rst_n(rst_n), .scan_o(scan_o), .ret_n(ret_n),
        .shift_i(shift_i), .ctrl_i(ctrl_i), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    // Active row as seen on the lines, for either scan style
    function automatic int row_of(input logic [7:0] s);
        int r = 0;
        if (s[7:3] == 5'b0) return int'(s[2:0]);
        for (int i = 0; i < 8; i++) if (!s[i]) r = i;
        return r;
    endfunction

    // Key matrix model
    always_comb begin
        cur_row = row_of(scan_o);
        ret_n = '1;
        for (int c = 0; c < 8; c++)
            if (pressed[cur_row * 8 + c]) ret_n[c] = 1'b0;
    end

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic get_status(output logic [7:0] s);
        @(negedge clk); rd_sel = 1'b1; rd_en = 1'b0;
        #1 s = rd_data;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); rd_sel = 1'b0; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_scans(input int n);
        repeat (n * SCAN) @(posedge clk);
    endtask

    task automatic set_key(input int r, input int c, input logic v);
        pressed[r * 8 + c] = v;
    endtask

    task automatic tap(input int r, input int c);
        set_key(r, c, 1'b1); wait_scans(3);
        set_key(r, c, 1'b0); wait_scans(2);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        @(negedge clk);
        check_eq("R1 scan lines in reset", scan_o, 8'hFE);
        check_eq("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        get_status(s);
        check_eq("R1 status after reset", s, 8'h00);
    endtask

    task automatic t_scan_pattern(input bit enc, input string req);
        int prev_r, now_r, trans = 0, bad_step = 0, bad_shape = 0;
        @(negedge clk); prev_r = row_of(scan_o);
        repeat (64) begin
            @(negedge clk);
            if (enc ? (scan_o[7:3] != 5'b0) : ($countones(~scan_o) != 1)) bad_shape++;
            now_r = row_of(scan_o);
            if (now_r != prev_r) begin
                trans++;
                if (now_r != (prev_r + 1) % 8) bad_step++;
                prev_r = now_r;
            end
        end
        check_eq({req, " line shape"}, bad_shape, 0);
        check_eq({req, " row order"}, bad_step, 0);
        check_eq({req, " dwell transitions"}, trans, 16);
    endtask

    task automatic t_single_key();
        logic [7:0] s, d;
        shift_i = 1'b1;
        set_key(3, 5, 1'b1); wait_scans(3);
        get_status(s);
        check_eq("R12 count after one key", s, 8'h01);
        check_eq("R12 irq with entry", irq, 1);
        set_key(3, 5, 1'b0); wait_scans(2);
        shift_i = 1'b0;
        get_status(s);
        check_eq("R5 held key gives one code", s, 8'h01);
        pop(d);
        check_eq("R6 code layout shift row3 col5", d, 8'h5D);
        check_eq("R12 irq after drain", irq, 0);
    endtask

    task automatic t_glitch();
        logic [7:0] s;
        set_key(1, 1, 1'b1);
        repeat (20) @(posedge clk);
        set_key(1, 1, 1'b0); wait_scans(3);
        get_status(s);
        check_eq("R5 short closure ignored", s, 8'h00);
    endtask

    task automatic t_retrigger();
        logic [7:0] s, d;
        tap(4, 4); tap(4, 4);
        get_status(s);
        check_eq("R5 re-press after release", s, 8'h02);
        pop(d); check_eq("R5 first code", d, 8'h24);
        pop(d); check_eq("R5 second code", d, 8'h24);
    endtask

    task automatic t_order();
        logic [7:0] d;
        ctrl_i = 1'b1; tap(0, 7);
        ctrl_i = 1'b0; shift_i = 1'b1; tap(7, 0);
        ctrl_i = 1'b1; tap(2, 3);
        ctrl_i = 1'b0; shift_i = 1'b0;
        pop(d); check_eq("R9 order first", d, 8'h87);
        pop(d); check_eq("R9 order second", d, 8'h78);
        pop(d); check_eq("R6 both modifiers", d, 8'hD3);
    endtask

    task automatic t_two_keys(input bit rollover);
        logic [7:0] s, d;
        set_key(1, 2, 1'b1); wait_scans(3);
        set_key(5, 0, 1'b1); wait_scans(3);
        get_status(s);
        if (rollover) check_eq("R8 both keys admitted", s, 8'h02);
        else          check_eq("R7 second key locked out", s, 8'h01);
        set_key(1, 2, 1'b0); wait_scans(3);
        get_status(s);
        check_eq(rollover ? "R8 no extra on release" : "R7 admitted after release", s, 8'h02);
        set_key(5, 0, 1'b0); wait_scans(2);
        pop(d); check_eq(rollover ? "R8 first" : "R7 first", d, 8'h0A);
        pop(d); check_eq(rollover ? "R8 second" : "R7 second", d, 8'h28);
    endtask

    task automatic t_overrun();
        logic [7:0] s, d;
        int zero_codes = 0;
        for (int r = 0; r < 8; r++) set_key(r, 1, 1'b1);
        set_key(0, 2, 1'b1);
        wait_scans(5);
        pressed = '0; wait_scans(2);
        get_status(s);
        check_eq("R10 full with overrun", s, 8'h48);
        for (int i = 0; i < 8; i++) begin
            pop(d);
            if (d == 8'h00) zero_codes++;
        end
        check_eq("R9 eight codes stored", zero_codes, 0);
        get_status(s);
        check_eq("R10 overrun held after drain", s, 8'h40);
        cpu_wr(8'hC0);
        get_status(s);
        check_eq("R11 clear drops overrun", s, 8'h00);
    endtask

    task automatic t_clear();
        logic [7:0] s;
        tap(2, 2); tap(3, 3);
        cpu_wr(8'h60); cpu_wr(8'h80); cpu_wr(8'hA0); cpu_wr(8'hE3);
        get_status(s);
        check_eq("R11 unused opcodes keep queue", s, 8'h02);
        check_eq("R11 unused opcodes keep decoded scan", $countones(~scan_o), 1);
        cpu_wr(8'hC0);
        get_status(s);
        check_eq("R11 clear empties queue", s, 8'h00);
        check_eq("R11 irq after clear", irq, 0);
    endtask

    task automatic t_empty_read();
        logic [7:0] s, d;
        pop(d);
        check_eq("R12 empty read value", d, 8'h00);
        get_status(s);
        check_eq("R12 empty read no change", s, 8'h00);
    endtask

    task automatic t_encoded();
        logic [7:0] d;
        cpu_wr(8'h01);
        t_scan_pattern(1'b1, "R3");
        ctrl_i = 1'b1; tap(6, 1); ctrl_i = 1'b0;
        pop(d);
        check_eq("R3 key through encoded scan", d, 8'hB1);
        cpu_wr(8'h00);
    endtask

    task automatic max_row(output int m, output int lo);
        int r;
        m = 0; lo = 7;
        repeat (8) @(negedge clk);
        repeat (64) begin
            @(negedge clk);
            r = row_of(scan_o);
            if (r > m) m = r;
            if (r < lo) lo = r;
        end
    endtask

    task automatic t_size();
        int m, lo;
        logic [7:0] s, d;
        cpu_wr(8'h23);
        max_row(m, lo);
        check_eq("R4 four rows top", m, 3);
        set_key(6, 0, 1'b1); wait_scans(3); set_key(6, 0, 1'b0); wait_scans(2);
        get_status(s);
        check_eq("R4 row beyond limit not scanned", s, 8'h00);
        cpu_wr(8'h20);
        max_row(m, lo);
        check_eq("R4 zero raised to two rows", m, 1);
        check_eq("R4 row zero still visited", lo, 0);
        cpu_wr(8'h27);
        cpu_wr(8'h42);
        tap(2, 5);
        get_status(s);
        check_eq("R4 column beyond limit ignored", s, 8'h00);
        tap(2, 2);
        pop(d);
        check_eq("R4 column inside limit", d, 8'h12);
        cpu_wr(8'h47);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        t_reset();
        t_scan_pattern(1'b0, "R2");
        t_single_key();
        t_glitch();
        t_retrigger();
        t_order();
        t_two_keys(1'b0);
        cpu_wr(8'h02);
        t_two_keys(1'b1);
        t_overrun();
        cpu_wr(8'h00);
        t_clear();
        t_empty_read();
        t_encoded();
        t_size();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule